// File: doc/BRIEF.md
# Strobed Latched Input Port

This block takes one byte from a peripheral and holds it for a host processor. The peripheral places a byte on the data lines and pulls an active-low strobe. Once the strobe has stayed low long enough to count as real, the block latches the byte and raises a buffer-full flag. When the strobe returns high and interrupts are enabled, it raises an interrupt request so the host knows there is data to fetch.

The host fetches the byte with an active-low read. The start of the read withdraws the interrupt request. The end of the read empties the buffer-full flag, which tells the peripheral that it may send the next byte. A single enable bit is loaded through a one-cycle host write strobe. The strobe and read lines may be asynchronous. Each passes through a two-flop synchroniser, and all edges are taken from the synchronised levels on one clock.

Top module: `strobed_input_port`

## Requirements
- R1: After reset, `full_o` and `irq_o` are 0, the interrupt enable is 0 and the latch holds 0x00, so a read returns 0x00.
- R2: A strobe counts only when `stb_n` is sampled low on at least `STB_MIN` consecutive rising clock edges. A shorter pulse changes neither the flags nor the latch.
- R3: A strobe that counts latches `pin_data` and sets `full_o`. `full_o` goes high on the (`STB_MIN`+2)-th rising edge at which `stb_n` is sampled low.
- R4: When a counted strobe returns high, `irq_o` is set if the enable is 1 and `full_o` is still 1. With the enable at 0, `irq_o` stays 0.
- R5: The start of a host read (`rd_n` going low, after synchronisation) clears `irq_o`. It leaves `full_o` unchanged.
- R6: The end of a host read (`rd_n` going high, after synchronisation) clears `full_o`.
- R7: While the synchronised `rd_n` is low, `host_dout` shows the latched byte. At all other times `host_dout` is 0x00.
- R8: A strobe that counts while `full_o` is already 1 overwrites the latch, and `full_o` stays 1.
- R9: On a clock edge where `cfg_we` is 1, the interrupt enable takes the value of `cfg_ie`. At other times the enable holds its value.
- R10: If a read completes while the strobe is still low, `full_o` is 0 when the strobe ends, so no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| pin_data | input | 8 | Byte presented by the peripheral |
| stb_n | input | 1 | Active-low strobe from the peripheral (asynchronous) |
| full_o | output | 1 | Buffer-full flag sent back to the peripheral |
| irq_o | output | 1 | Interrupt request to the host |
| rd_n | input | 1 | Active-low host read (asynchronous) |
| host_dout | output | 8 | Latched byte while a read is in progress, otherwise 0x00 |
| cfg_we | input | 1 | Host write strobe for the enable bit |
| cfg_ie | input | 1 | Value written to the interrupt enable |

## Verification
A wrong pulse-length count shows up as `full_o` rising one edge too early or too late. It also shows up as a short strobe that sets the flag when it should not. Both appear within `STB_MIN`+2 cycles of the strobe falling. A wrong latch or a missed overwrite shows up on `host_dout` two cycles into the next read. Flag sequencing errors, such as a lost interrupt clear or a full flag that clears too early, appear at `irq_o` or `full_o` on the third edge after the read line moves.

// File: rtl/sip_pkg.sv
package sip_pkg;
  typedef struct packed {
    logic fall;
    logic rise;
  } edge_ev_t;
endpackage

// File: rtl/sip_rst_sync.sv
module sip_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= 2'b00;
    else         chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_n_o = chain_q[1];
endmodule

// File: rtl/sip_sync_bits.sv
module sip_sync_bits #(
  parameter int W       = 2,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_rest
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= IDLE;
      else        stage_q[s] <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sip_strobe_qual.sv
module sip_strobe_qual
  import sip_pkg::*;
#(
  parameter int STB_MIN = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     lvl_n,
  output edge_ev_t ev
);
  localparam int CW = $clog2(STB_MIN + 1);
  localparam logic [CW-1:0] LIM = CW'(STB_MIN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          cnt_en;

  assign ev.fall = !lvl_n && !act_q && (cnt_q == LIM);
  assign ev.rise = lvl_n && act_q;
  assign cnt_en  = lvl_n || (cnt_q != LIM);

  always_comb begin
    cnt_d = cnt_q;
    if (lvl_n)              cnt_d = '0;
    else if (cnt_q != LIM)  cnt_d = cnt_q + 1'b1;
    act_d = act_q;
    if (ev.fall)      act_d = 1'b1;
    else if (ev.rise) act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/strobed_input_port.sv
module strobed_input_port
  import sip_pkg::*;
#(
  parameter int DW      = 8,
  parameter int STB_MIN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pin_data,
  input  logic          stb_n,
  output logic          full_o,
  output logic          irq_o,
  input  logic          rd_n,
  output logic [DW-1:0] host_dout,
  input  logic          cfg_we,
  input  logic          cfg_ie
);
  logic          rst_i_n;
  logic [1:0]    lvl_sync;
  logic          stb_lvl, rd_lvl;
  edge_ev_t      stb_ev;
  logic          rd_prev_q;
  logic          rd_fall, rd_rise;
  logic          full_q, full_d;
  logic          irq_q, irq_d;
  logic          ie_q, ie_d;
  logic [DW-1:0] latch_q;

  sip_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_i_n)
  );

  sip_sync_bits #(.W(2), .STAGES(2), .IDLE(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .din   ({rd_n, stb_n}),
    .dout  (lvl_sync)
  );

  assign stb_lvl = lvl_sync[0];
  assign rd_lvl  = lvl_sync[1];

  sip_strobe_qual #(.STB_MIN(STB_MIN)) u_qual (
    .clk   (clk),
    .rst_n (rst_i_n),
    .lvl_n (stb_lvl),
    .ev    (stb_ev)
  );

  assign rd_fall = !rd_lvl && rd_prev_q;
  assign rd_rise = rd_lvl && !rd_prev_q;

  always_comb begin
    full_d = full_q;
    if (rd_rise)     full_d = 1'b0;
    if (stb_ev.fall) full_d = 1'b1;
    irq_d = irq_q;
    if (rd_fall)     irq_d = 1'b0;
    if (stb_ev.rise && ie_q && full_q) irq_d = 1'b1;
    ie_d = cfg_we ? cfg_ie : ie_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rd_prev_q <= 1'b1;
      full_q    <= 1'b0;
      irq_q     <= 1'b0;
      ie_q      <= 1'b0;
    end else begin
      rd_prev_q <= rd_lvl;
      full_q    <= full_d;
      irq_q     <= irq_d;
      ie_q      <= ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)        latch_q <= '0;
    else if (stb_ev.fall) latch_q <= pin_data;
  end

  assign full_o    = full_q;
  assign irq_o     = irq_q;
  assign host_dout = rd_lvl ? '0 : latch_q;
endmodule

// File: rtl/sip_checker.sv
module sip_checker (
  input logic clk,
  input logic rst_n,
  input logic stb_fall,
  input logic stb_rise,
  input logic rd_fall,
  input logic rd_rise,
  input logic ie,
  input logic full,
  input logic irq
);
  AST_FULL_ONLY_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(stb_fall)); // R2
  AST_FALL_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    stb_fall |=> full); // R3
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(ie) && $past(full) && $past(stb_rise))); // R4
  AST_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && !stb_rise) |=> !irq); // R5
  AST_READ_END_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && !stb_fall) |=> !full); // R6
endmodule

bind strobed_input_port sip_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stb_fall (stb_ev.fall),
  .stb_rise (stb_ev.rise),
  .rd_fall  (rd_fall),
  .rd_rise  (rd_rise),
  .ie       (ie_q),
  .full     (full_q),
  .irq      (irq_q)
);

// File: tb/strobed_input_port_test.sv
module strobed_input_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int SMIN = 3;

  logic       clk = 1'b0;
  logic       rst_n, stb_n, rd_n, cfg_we, cfg_ie;
  logic [7:0] pin_data;
  logic       full_o, irq_o;
  logic [7:0] host_dout;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  logic       exp_full, exp_irq, exp_ie;
  logic [7:0] exp_latch;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobed_input_port #(.DW(8), .STB_MIN(SMIN)) uut (
    .clk(clk), .rst_n(rst_n), .pin_data(pin_data), .stb_n(stb_n),
    .full_o(full_o), .irq_o(irq_o), .rd_n(rd_n), .host_dout(host_dout),
    .cfg_we(cfg_we), .cfg_ie(cfg_ie)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ie(input logic v);
    @(negedge clk); cfg_we = 1'b1; cfg_ie = v;
    @(negedge clk); cfg_we = 1'b0; cfg_ie = ~v;
    exp_ie = v;
  endtask

  task automatic strobe(input int len, input logic [7:0] d);
    pin_data = d; stb_n = 1'b0;
    repeat (len) @(negedge clk);
    stb_n = 1'b1;
    repeat (6) @(negedge clk);
    if (len >= SMIN) begin
      exp_latch = d; exp_full = 1'b1;
      if (exp_ie) exp_irq = 1'b1;
      chk("R3", full_o, 1);
      chk("R4", irq_o, exp_irq);
    end else begin
      chk("R2", full_o, exp_full);
      chk("R2", irq_o, exp_irq);
    end
  endtask

  task automatic host_read();
    rd_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7", host_dout, exp_latch);
    chk("R5", irq_o, 0);
    chk("R5", full_o, exp_full);
    exp_irq = 1'b0;
    rd_n = 1'b1;
    repeat (5) @(negedge clk);
    exp_full = 1'b0;
    chk("R6", full_o, 0);
    chk("R7", host_dout, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stb_n = 1'b1; rd_n = 1'b1; cfg_we = 1'b0; cfg_ie = 1'b0;
    pin_data = 8'h00;
    exp_full = 0; exp_irq = 0; exp_ie = 0; exp_latch = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", full_o, 0);
    chk("R1", irq_o, 0);
    chk("R1", host_dout, 0);
    host_read();

    // R2/R3/R4/R9 sweep of pulse length with enable off and on
    for (int ie = 0; ie < 2; ie++) begin
      set_ie(ie[0]);
      for (int len = 1; len <= SMIN + 3; len++) begin
        strobe(len, 8'(8'h25 * len + ie * 8'h80));
        chk("R9", irq_o, (ie == 1 && len >= SMIN) ? 1 : 0);
        host_read();
      end
    end

    // R3 exact latency of full flag
    pin_data = 8'h3C; stb_n = 1'b0;
    repeat (SMIN + 1) @(negedge clk);
    chk("R3", full_o, 0);
    @(negedge clk);
    chk("R3", full_o, 1);
    stb_n = 1'b1;
    repeat (6) @(negedge clk);
    exp_full = 1'b1; exp_latch = 8'h3C; exp_irq = exp_ie;
    chk("R4", irq_o, exp_irq);
    host_read();

    // R3/R7 latch sweep over every byte value
    for (int v = 0; v < 256; v++) begin
      strobe(SMIN, 8'(v));
      host_read();
    end

    // R8 overwrite while full
    strobe(SMIN, 8'hA5);
    strobe(SMIN + 1, 8'h5A);
    chk("R8", full_o, 1);
    rd_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", host_dout, 8'h5A);
    rd_n = 1'b1;
    repeat (5) @(negedge clk);
    exp_full = 0; exp_irq = 0;

    // R10 read completes inside a long strobe
    set_ie(1'b1);
    pin_data = 8'hC3; stb_n = 1'b0;
    repeat (SMIN + 3) @(negedge clk);
    chk("R3", full_o, 1);
    rd_n = 1'b0; repeat (3) @(negedge clk);
    rd_n = 1'b1; repeat (5) @(negedge clk);
    chk("R10", full_o, 0);
    stb_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10", irq_o, 0);
    chk("R10", full_o, 0);
    exp_latch = 8'hC3; exp_full = 0; exp_irq = 0;
    host_read();

    // R9 enable cleared again blocks the interrupt
    set_ie(1'b0);
    strobe(SMIN, 8'h77);
    chk("R9", irq_o, 0);
    host_read();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule